// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing slave controller of a byte-addressed serial memory on a two-wire (I2C-style) bus. It watches already-synchronised SCL and SDA lines and detects start and stop conditions. It compares the device address byte against a fixed code and a three-bit strap value, and it acknowledges by driving an open-drain pull-down enable. Writes carry two word-address bytes and then data bytes, which leave the block one strobe per byte on a write port. Reads take data from a read port addressed by an internal counter. That counter persists between transactions, so a current-address read continues where the last access stopped.

A random read is done with a write header that carries only the word address, then a repeated start and a read header. A sequential read continues for as long as the host acknowledges each byte. A stop that ends a transfer in which data was written produces a commit pulse, and the memory side then runs its programming cycle. While the memory side reports busy, the block declines to acknowledge its address, so the host can poll until the write cycle is complete.

Top module: `serial_mem_slave`

## Requirements
- R1: A start (SDA falls while SCL is high) restarts address reception from any state. A stop (SDA rises while SCL is high) returns the block to idle from any state, including the middle of a byte. After either, the pull-down is released.
- R2: The device byte is received MSB first. Bits 7..4 must be 1010, bits 3..1 must equal `dev_sel_i`, and bit 0 selects read (1) or write (0). On a match the pull-down is held during the ninth clock. On a mismatch SDA stays released and every bit up to the next start is ignored.
- R3: While `wr_busy_i` is high at the end of the device byte, the block does not acknowledge, even when the address matches.
- R4: In a write header, the high word-address byte and then the low word-address byte are each acknowledged. Only the low AW-8 bits of the high byte are used, and its upper bits are ignored.
- R5: Each data byte of a write is acknowledged and produces exactly one single-cycle `wr_en_o` pulse, carrying the byte and the address counter value. The pulse occurs while SCL is low.
- R6: Within a write, the address advances only in its low 5 bits and wraps inside the 32-byte page, while the upper bits stay fixed.
- R7: A stop that ends a transfer with at least one written data byte gives one single-cycle `wr_commit_o` pulse. A transfer with no data byte gives none.
- R8: A current-address read returns the byte at the internal counter. That counter holds the last accessed address plus one (page-wrapped after a write, array-wrapped after a read).
- R9: A random read (write header with word address, repeated start, read header) returns data starting at the loaded address.
- R10: In a read, a host acknowledge after a byte makes the block send the byte at the next address. A host non-acknowledge releases SDA and ends the transfer.
- R11: During reads the counter wraps from the top address (2^AW-1, 8191 by default) to 0.
- R12: The pull-down only turns on while SCL is low. It is released after the SCL fall that ends an acknowledge bit, so the host drives SDA again.
- R13: During reset the pull-down is released, `wr_en_o` and `wr_commit_o` are low, and the address counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| dev_sel_i | input | 3 | Strapped device select value |
| wr_busy_i | input | 1 | Memory side is in its write cycle |
| rd_data_i | input | 8 | Byte stored at `rd_addr_o` |
| sda_pull_o | output | 1 | Open-drain pull-down enable for SDA |
| rd_addr_o | output | AW | Internal address counter, read address |
| wr_en_o | output | 1 | Single-cycle write strobe per data byte |
| wr_addr_o | output | AW | Address of the byte being written |
| wr_data_o | output | 8 | Byte being written |
| wr_commit_o | output | 1 | Pulse at stop after written data |

## Verification
SCL and SDA edges are seen in the first clock in which the new level is present. The pull-down, the write strobe and the counter therefore change one clock after the SCL fall that causes them, and the commit pulse comes one clock after the stop edge. The bench changes and samples the bus only on negative clock edges, four clocks after each bus transition, so every result has settled before it is read. It checks write strobes and the commit count a few clocks after the stop, against a model of the memory and the counter that the bench keeps itself. Read data and acknowledges are sampled in the middle of the SCL high phase, as a host would sample them.

// File: rtl/sm_pkg.sv
// Shared types for the serial memory slave.
// Assumes: nothing beyond the enum encoding being internal only.
package sm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // ignoring the bus until a start
        ST_DEV,    // receiving device byte
        ST_ADRH,   // receiving high word-address byte
        ST_ADRL,   // receiving low word-address byte
        ST_WDAT,   // receiving write data bytes
        ST_ACK,    // slave acknowledge bit in progress
        ST_RDAT,   // sending read data byte
        ST_RACK    // host acknowledge bit after read data
    } sm_state_e;
endpackage

// File: rtl/sm_line_watch.sv
// Bus condition detector: registers SCL/SDA once and flags SCL edges,
// start and stop conditions for the current clock.
// Assumes inputs are already synchronised and each SCL phase lasts
// at least two clocks.
module sm_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    // Hold the previous line levels; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/sm_addr_ctr.sv
// Word address counter: loadable, with a full-array increment for reads
// and a page-confined increment for writes.
// Assumes at most one control is active per clock (load wins).
module sm_addr_ctr #(
    parameter int AW        = 13,
    parameter int PAGE_BITS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          inc_full_i,
    input  logic          inc_page_i,
    output logic [AW-1:0] addr_o
);
    localparam int UPPER = AW - PAGE_BITS;

    logic [AW-1:0]        addr_q;
    logic [PAGE_BITS-1:0] page_off;

    assign page_off = addr_q[PAGE_BITS-1:0] + 1'b1;

    // Update the counter: load, wrap over the array, or wrap in the page.
    always_ff @(posedge clk) begin
        if (!rst_n)          addr_q <= '0;
        else if (load_i)     addr_q <= load_val_i;
        else if (inc_full_i) addr_q <= addr_q + 1'b1;
        else if (inc_page_i) addr_q <= {addr_q[AW-1:AW-UPPER], page_off};
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/serial_mem_slave.sv
// Two-wire serial memory slave: protocol state machine around the
// condition detector and the word address counter. Writes leave as one
// strobe per byte plus a commit pulse at stop; reads use a combinational
// read port addressed by the counter.
// Assumes synchronised inputs, SCL phases of at least three clocks, and
// rd_data_i valid within one SCL period after rd_addr_o changes.
module serial_mem_slave #(
    parameter int         AW        = 13,
    parameter int         PAGE_BITS = 5,
    parameter logic [3:0] DEV_CODE  = 4'b1010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [2:0]    dev_sel_i,
    input  logic          wr_busy_i,
    input  logic [7:0]    rd_data_i,
    output logic          sda_pull_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [7:0]    wr_data_o,
    output logic          wr_commit_o
);
    import sm_pkg::*;

    localparam int HI_BITS = AW - 8;

    logic scl_rise, scl_fall, start_det, stop_det;

    sm_state_e           state_q, next_q;
    logic [3:0]          bitcnt_q;
    logic [7:0]          shreg_q;
    logic [HI_BITS-1:0]  hi_q;
    logic                pull_q, wrote_q, hack_q;
    logic                wr_en_q, commit_q;
    logic [AW-1:0]       wr_addr_q;
    logic [7:0]          wr_data_q;

    logic                rx_state, byte_end, dev_match;
    logic                ctr_load, ctr_inc_full, ctr_inc_page;
    logic [AW-1:0]       ctr_addr;

    sm_line_watch u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    sm_addr_ctr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ctr_load),
        .load_val_i ({hi_q, shreg_q}),
        .inc_full_i (ctr_inc_full),
        .inc_page_i (ctr_inc_page),
        .addr_o     (ctr_addr)
    );

    // Derive byte-boundary events and counter controls for this clock.
    always_comb begin
        rx_state     = (state_q == ST_DEV) || (state_q == ST_ADRH) ||
                       (state_q == ST_ADRL) || (state_q == ST_WDAT);
        byte_end     = rx_state && scl_fall && (bitcnt_q == 4'd8);
        dev_match    = (shreg_q[7:1] == {DEV_CODE, dev_sel_i});
        ctr_load     = byte_end && (state_q == ST_ADRL);
        ctr_inc_page = byte_end && (state_q == ST_WDAT);
        ctr_inc_full = (state_q == ST_RDAT) && scl_fall && (bitcnt_q == 4'd7);
    end

    // Protocol state machine, shift register and SDA pull-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            next_q    <= ST_IDLE;
            bitcnt_q  <= '0;
            shreg_q   <= '0;
            hi_q      <= '0;
            pull_q    <= 1'b0;
            wrote_q   <= 1'b0;
            hack_q    <= 1'b0;
            wr_en_q   <= 1'b0;
            commit_q  <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q  <= 1'b0;
            commit_q <= 1'b0;
            if (start_det) begin
                state_q  <= ST_DEV;
                bitcnt_q <= '0;
                pull_q   <= 1'b0;
            end else if (stop_det) begin
                state_q  <= ST_IDLE;
                pull_q   <= 1'b0;
                commit_q <= wrote_q;
                wrote_q  <= 1'b0;
            end else if (rx_state) begin
                if (scl_rise && bitcnt_q < 4'd8) begin
                    shreg_q  <= {shreg_q[6:0], sda_i};
                    bitcnt_q <= bitcnt_q + 1'b1;
                end else if (byte_end) begin
                    bitcnt_q <= '0;
                    pull_q   <= 1'b1;
                    state_q  <= ST_ACK;
                    unique case (state_q)
                        ST_DEV: begin
                            if (dev_match && !wr_busy_i) begin
                                next_q <= shreg_q[0] ? ST_RDAT : ST_ADRH;
                            end else begin
                                pull_q  <= 1'b0;
                                state_q <= ST_IDLE;
                            end
                        end
                        ST_ADRH: begin
                            hi_q   <= shreg_q[HI_BITS-1:0];
                            next_q <= ST_ADRL;
                        end
                        ST_ADRL: next_q <= ST_WDAT;
                        default: begin
                            wr_en_q   <= 1'b1;
                            wr_addr_q <= ctr_addr;
                            wr_data_q <= shreg_q;
                            wrote_q   <= 1'b1;
                            next_q    <= ST_WDAT;
                        end
                    endcase
                end
            end else if (state_q == ST_ACK) begin
                if (scl_fall) begin
                    state_q  <= next_q;
                    bitcnt_q <= '0;
                    if (next_q == ST_RDAT) begin
                        shreg_q <= rd_data_i;
                        pull_q  <= ~rd_data_i[7];
                    end else begin
                        pull_q  <= 1'b0;
                    end
                end
            end else if (state_q == ST_RDAT) begin
                if (scl_fall) begin
                    if (bitcnt_q == 4'd7) begin
                        pull_q   <= 1'b0;
                        state_q  <= ST_RACK;
                        bitcnt_q <= '0;
                    end else begin
                        shreg_q  <= {shreg_q[6:0], 1'b0};
                        pull_q   <= ~shreg_q[6];
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                end
            end else if (state_q == ST_RACK) begin
                if (scl_rise) hack_q <= ~sda_i;
                if (scl_fall) begin
                    if (hack_q) begin
                        shreg_q  <= rd_data_i;
                        pull_q   <= ~rd_data_i[7];
                        state_q  <= ST_RDAT;
                        bitcnt_q <= '0;
                    end else begin
                        state_q  <= ST_IDLE;
                    end
                end
            end
        end
    end

    assign sda_pull_o  = pull_q;
    assign rd_addr_o   = ctr_addr;
    assign wr_en_o     = wr_en_q;
    assign wr_addr_o   = wr_addr_q;
    assign wr_data_o   = wr_data_q;
    assign wr_commit_o = commit_q;
endmodule

// File: rtl/sm_slave_checker.sv
// Protocol checker for the serial memory slave, bound to its top.
// Assumes the host never forces a start or stop while the slave pulls SDA.
module sm_slave_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic sda_pull_o,
    input logic wr_en_o,
    input logic wr_commit_o
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!sda_pull_o && !wr_en_o && !wr_commit_o)); // R13

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && $past(sda_i) && !sda_i) |=> !sda_pull_o); // R1

    AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_i); // R12

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o); // R5

    AST_WR_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> !scl_i); // R5

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |=> !wr_commit_o); // R7

    AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |-> (scl_i && sda_i)); // R7
endmodule

bind serial_mem_slave sm_slave_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .sda_pull_o  (sda_pull_o),
    .wr_en_o     (wr_en_o),
    .wr_commit_o (wr_commit_o)
);

// File: tb/tb_serial_mem_slave.sv
`timescale 1ns/1ps
// Bench: bit-banged host, behavioural memory with busy timer, own
// expected memory and address pointer.
module tb_serial_mem_slave;
    localparam int AW = 13;
    localparam int Q  = 4;
    localparam int TOP = (1 << AW) - 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, scl, sda_m, wr_busy, pull, wr_en, commit;
    logic [2:0]    sel;
    logic [7:0]    rd_data, wr_data;
    logic [AW-1:0] rd_addr, wr_addr;
    wire           sda_bus = sda_m & ~pull;

    serial_mem_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .dev_sel_i(sel), .wr_busy_i(wr_busy), .rd_data_i(rd_data),
        .sda_pull_o(pull), .rd_addr_o(rd_addr), .wr_en_o(wr_en),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_commit_o(commit)
    );

    int n_chk = 0, n_fail = 0, commit_cnt = 0, busy_cnt = 0, exp_ptr = 0;
    int wq_a[$], wq_d[$];
    logic [7:0] dmem [int];
    logic [7:0] emem [int];

    function automatic logic [7:0] fill(int a);
        return 8'((a * 29) ^ (a >> 4) ^ 8'h5A);
    endfunction
    function automatic logic [7:0] exp_rd(int a);
        return emem.exists(a) ? emem[a] : fill(a);
    endfunction
    function automatic int pg(int a, int k);
        return (a & ~31) | ((a + k) & 31);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory side: read port, write capture, busy timer after commit.
    always @(negedge clk) rd_data <= dmem.exists(int'(rd_addr)) ? dmem[int'(rd_addr)] : fill(int'(rd_addr));
    always @(posedge clk) begin
        if (wr_en) begin
            dmem[int'(wr_addr)] = wr_data;
            wq_a.push_back(int'(wr_addr));
            wq_d.push_back(int'(wr_data));
        end
        if (commit) commit_cnt++;
    end
    always @(posedge clk) begin
        if (!rst_n)          busy_cnt <= 0;
        else if (commit)     busy_cnt <= 200;
        else if (busy_cnt>0) busy_cnt <= busy_cnt - 1;
    end
    assign wr_busy = (busy_cnt != 0);

    task automatic hw(); repeat (Q) @(negedge clk); endtask
    task automatic h_start(); sda_m = 1; hw(); scl = 1; hw(); sda_m = 0; hw(); scl = 0; hw(); endtask
    task automatic h_stop();  sda_m = 0; hw(); scl = 1; hw(); sda_m = 1; hw(); endtask
    task automatic put_bit(bit b); sda_m = b; hw(); scl = 1; hw(); hw(); scl = 0; hw(); endtask
    task automatic get_bit(output bit b); sda_m = 1; hw(); scl = 1; hw(); b = sda_bus; hw(); scl = 0; hw(); endtask
    task automatic tx_byte(logic [7:0] b, output bit ack);
        bit x;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(x);
        ack = !x;
    endtask
    task automatic rx_byte(bit host_ack, output logic [7:0] d);
        bit x;
        for (int i = 7; i >= 0; i--) begin get_bit(x); d[i] = x; end
        put_bit(!host_ack);
    endtask
    function automatic logic [7:0] devb(bit rw); return {4'b1010, sel, rw}; endfunction

    task automatic poll_ready();
        bit ack = 0;
        for (int t = 0; t < 40 && !ack; t++) begin h_start(); tx_byte(devb(0), ack); h_stop(); end
        chk(ack, "R3 ready after busy", ack, 1);
    endtask

    // Write header plus n random data bytes; checks strobes and commit.
    task automatic write_txn(int a, int n, logic [7:0] junk, bit poll);
        bit ack; int c0 = commit_cnt; int ea[$]; int ed[$];
        logic [7:0] d;
        wq_a.delete(); wq_d.delete();
        h_start();
        tx_byte(devb(0), ack); chk(ack, "R2 device ack", ack, 1);
        tx_byte(8'(a >> 8) | junk, ack); chk(ack, "R4 high addr ack", ack, 1);
        tx_byte(8'(a), ack); chk(ack, "R4 low addr ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            tx_byte(d, ack); chk(ack, "R5 data ack", ack, 1);
            ea.push_back(pg(a, k)); ed.push_back(int'(d)); emem[pg(a, k)] = d;
        end
        h_stop(); hw();
        chk(wq_a.size() == n, "R5 strobe count", wq_a.size(), n);
        for (int k = 0; k < n && k < wq_a.size(); k++) begin
            chk(wq_a[k] == ea[k], "R6 write address", wq_a[k], ea[k]);
            chk(wq_d[k] == ed[k], "R5 write data", wq_d[k], ed[k]);
        end
        chk(commit_cnt == c0 + 1, "R7 commit pulse", commit_cnt - c0, 1);
        exp_ptr = pg(a, n);
        if (poll) poll_ready();
    endtask

    // Optional random-address header, then n sequential reads.
    task automatic read_txn(bit rnd, int a, int n, logic [7:0] junk, string req);
        bit ack; logic [7:0] d; int c0 = commit_cnt;
        h_start();
        if (rnd) begin
            tx_byte(devb(0), ack);
            tx_byte(8'(a >> 8) | junk, ack);
            tx_byte(8'(a), ack); chk(ack, "R9 addr ack", ack, 1);
            exp_ptr = a;
            h_start();
        end
        tx_byte(devb(1), ack); chk(ack, "R2 read header ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            rx_byte(k < n - 1, d);
            chk(d == exp_rd(exp_ptr), req, d, exp_rd(exp_ptr));
            exp_ptr = (exp_ptr + 1) & TOP;
        end
        chk(!pull, "R10 released after host nack", pull, 0);
        h_stop(); hw();
        chk(commit_cnt == c0, "R7 no commit without data", commit_cnt - c0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit ack, x;
        int a, n, op;
        void'($urandom(32'd24681));
        rst_n = 0; scl = 1; sda_m = 1; sel = 3'b101;
        repeat (5) @(negedge clk);
        chk(!pull && !wr_en && !commit, "R13 reset outputs", {pull, wr_en, commit}, 0);
        chk(rd_addr == 0, "R13 reset counter", rd_addr, 0);
        rst_n = 1; hw();

        // Byte write, then immediate poll while busy must be declined.
        write_txn(100, 1, 8'h00, 0);
        h_start(); tx_byte(devb(0), ack); h_stop();
        chk(!ack, "R3 nack while busy", ack, 0);
        poll_ready();
        read_txn(0, 0, 1, 8'h00, "R8 current address read");
        read_txn(1, 100, 1, 8'h00, "R9 random read");
        read_txn(1, 96, 5, 8'h00, "R10 sequential read");

        // Page wrap and top-of-array wrap.
        write_txn(32 * 7 + 29, 5, 8'h00, 1);
        read_txn(1, 32 * 7, 32, 8'h00, "R6 page contents");
        write_txn(TOP - 1, 2, 8'h00, 1);
        read_txn(1, TOP - 1, 4, 8'h00, "R11 read wrap");
        read_txn(0, 0, 1, 8'h00, "R11 counter after wrap");
        read_txn(1, 4000, 2, 8'hE0, "R4 unused high bits ignored");

        // Release timing after an acknowledge.
        h_start(); tx_byte(devb(0), ack);
        chk(!pull, "R12 release after ack", pull, 0);
        h_stop();

        // Address mismatch: strap bits, then upper nibble.
        wq_a.delete();
        h_start(); tx_byte({4'b1010, sel ^ 3'b001, 1'b0}, ack);
        chk(!ack, "R2 select mismatch nack", ack, 0);
        tx_byte(8'h00, ack); chk(!ack, "R2 ignored after mismatch", ack, 0);
        h_stop(); hw();
        chk(wq_a.size() == 0, "R2 no write after mismatch", wq_a.size(), 0);
        h_start(); tx_byte({4'b1011, sel, 1'b1}, ack);
        chk(!ack, "R2 code mismatch nack", ack, 0);
        h_stop();

        // Abort mid-byte by stop, then by repeated start.
        h_start(); for (int i = 0; i < 4; i++) put_bit(i[0]);
        h_stop(); hw();
        chk(!pull, "R1 idle after mid-byte stop", pull, 0);
        h_start(); for (int i = 0; i < 3; i++) put_bit(1'b0);
        read_txn(0, 0, 2, 8'h00, "R1 read after mid-byte start");

        // Constrained random mix.
        for (int it = 0; it < 16; it++) begin
            op = $urandom % 3;
            a  = $urandom & TOP;
            n  = 1 + ($urandom % 4);
            if (op == 0)      write_txn(a, n, 8'($urandom) & 8'hE0, 1);
            else if (op == 1) read_txn(1, a, n, 8'h00, "R9 random mix read");
            else              read_txn(0, 0, n, 8'h00, "R8 random mix current read");
        end
        get_bit(x);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule